// File: doc/BRIEF.md
# DAC Update and Double-Buffer Controller

This block is the digital front end of a 12-bit digital-to-analog converter. It lives in the peripheral clock domain and holds two code registers. The live register drives the converter code. The pending register receives buffered writes. An asynchronous update-clock input and an asynchronous strobe input each pass through a two-flop synchronizer, and their rising edges are detected in the peripheral clock domain. These edges decide when the pending value moves into the live register. The rule that decides this is one of five update modes, chosen by configuration.

Each pending-to-live move raises a trigger pulse that clears itself after two cycles, for example to request the next sample from a DMA engine. The same move sets a sticky interrupt status bit that stays set until software clears it, and an enable bit gates this status onto the interrupt line.

The live value is formatted on its way to the converter. It can be read as unsigned or as two's complement, and a saturating plus-one option can be added. Every update can also hold one of two output switches open for a programmable number of cycles, which hides the converter's glitch. The two switches are the buffered-path switch and the direct-pin switch.

Top module: `dac_update_ctrl`

## Requirements
- R1: In mode 0 (direct), a cycle with `wr_cur_en` high loads `wr_data[11:0]` into the live register, and `dac_code` shows it after that clock edge. Direct writes never raise `trig_out` or `irq_status`.
- R2: Writes to the pending register never reach `dac_code` in mode 0. `wr_cur_en` is ignored in every mode other than 0. Mode codes 5 to 7 perform no update at all.
- R3: In mode 1 (buffered), each rising edge of `upd_clk_in` copies the pending value into the live register. The new value is visible after the third peripheral clock edge that follows the input change.
- R4: Every pending-to-live transfer drives `trig_out` high for exactly two peripheral clock cycles, starting right after the transfer edge.
- R5: A transfer sets `irq_status`, and the bit stays set until a cycle with `irq_clr` high (write-1-to-clear). If a transfer and a clear fall in the same cycle, the transfer wins.
- R6: In mode 2 (strobe-armed), a rising edge of `strobe_in` arms exactly one transfer, and that transfer happens at the next rising edge of the update clock. Update-clock edges while the block is not armed do nothing.
- R7: In mode 3 (strobe-immediate), each rising edge of `strobe_in` transfers the pending value, whatever `upd_clk_in` does.
- R8: In mode 4 (strobe-level), update-clock rising edges transfer only while the synchronized strobe is high. While the strobe is low, no transfer happens.
- R9: Only bits 11:0 of `wr_data` are stored. With `cfg_signed` = 1, the output code is the stored value plus 0x800, modulo 4096.
- R10: With `cfg_plus_one` = 1, the output code is the formatted value plus one, and a result of 0xFFF stays at 0xFFF.
- R11: `irq_out` equals `irq_status` AND `cfg_irq_en`. The enable bit has no effect on the status bit.
- R12: With `cfg_dgl_en` = 1, every update (a direct write or a transfer) opens one switch for exactly `cfg_dgl_cycles` cycles. `cfg_dgl_path` = 1 selects `sw_buf_open` and `cfg_dgl_path` = 0 selects `sw_pin_open`. The other switch stays closed.
- R13: After reset, `dac_code`, `trig_out`, `irq_status`, `irq_out` and both switch outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Peripheral clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_mode | input | 3 | Update mode: 0 direct, 1 buffered, 2 strobe-armed, 3 strobe-immediate, 4 strobe-level |
| cfg_signed | input | 1 | Treat the stored value as two's complement |
| cfg_plus_one | input | 1 | Add one to the output code, saturating |
| cfg_irq_en | input | 1 | Gates the status bit onto the interrupt line |
| cfg_dgl_en | input | 1 | Enables the deglitch switch timer |
| cfg_dgl_path | input | 1 | Selects the switch: 1 buffered-path switch, 0 direct-pin switch |
| cfg_dgl_cycles | input | 8 | Deglitch duration in cycles |
| wr_cur_en | input | 1 | Write strobe for the live register |
| wr_nxt_en | input | 1 | Write strobe for the pending register |
| wr_data | input | 16 | Write data; only the low 12 bits are used |
| irq_clr | input | 1 | Clears the interrupt status bit |
| upd_clk_in | input | 1 | Asynchronous update clock |
| strobe_in | input | 1 | Asynchronous strobe |
| dac_code | output | 12 | Code sent to the converter |
| trig_out | output | 1 | Two-cycle transfer trigger |
| irq_status | output | 1 | Sticky transfer status bit |
| irq_out | output | 1 | Interrupt line |
| sw_pin_open | output | 1 | Holds the direct-pin switch open |
| sw_buf_open | output | 1 | Holds the buffered-path switch open |

## Verification
The bench goes after the corner cases that separate the five modes:
- Update-clock edges that arrive before the strobe has armed the block must do nothing. A design that arms on the strobe level, or that lets an arm cover more than one transfer, would update the code too early or twice.
- In strobe-level mode, clock edges while the strobe is low must be dropped. A design that ignores the gate would update the code anyway.
- A direct-mode write must leave the trigger and interrupt quiet. A design that treats it as a transfer would fire both.

The bench also targets the timing and formatting edges:
- The trigger must be exactly two cycles long, and the deglitch window exactly the programmed length. A counter that is off by one would show one cycle too many or too few.
- Signed mode must add 0x800 to the stored value.
- Plus-one mode must saturate at 0xFFF. A design that wraps would send 0x000 instead.

A behavioural model that counts synchronizer delay is compared with every output on every cycle. This comparison catches a transfer landing one edge early or late.

// File: rtl/dac_upd_pkg.sv
package dac_upd_pkg;

    typedef enum logic [2:0] {
        UPD_DIRECT    = 3'd0,
        UPD_BUFFERED  = 3'd1,
        UPD_STB_ARM   = 3'd2,
        UPD_STB_IMM   = 3'd3,
        UPD_STB_LEVEL = 3'd4
    } upd_mode_e;

    localparam int TRIG_LEN = 2;

endpackage

// File: rtl/dac_edge_sync.sv
module dac_edge_sync (
    input  logic clk,
    input  logic rst_n,
    input  logic async_in,
    output logic level_o,
    output logic rise_o
);
    // [0] first stage, [1] second stage, [2] previous second-stage value
    logic [2:0] sh_q, sh_d;

    always_comb begin
        sh_d = {sh_q[1:0], async_in};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sh_q <= '0;
        else        sh_q <= sh_d;
    end

    assign level_o = sh_q[1];
    assign rise_o  = sh_q[1] & ~sh_q[2];

    // R3: a detected rise lasts one cycle only
    p_rise_single_r3: assert property (@(posedge clk) disable iff (!rst_n)
        rise_o |=> !rise_o);

endmodule

// File: rtl/dac_code_fmt.sv
module dac_code_fmt #(
    parameter int CODE_W = 12
) (
    input  logic [CODE_W-1:0] val_i,
    input  logic              signed_i,
    input  logic              plus_one_i,
    output logic [CODE_W-1:0] code_o
);
    localparam logic [CODE_W-1:0] OFFSET = {1'b1, {(CODE_W-1){1'b0}}};
    localparam logic [CODE_W-1:0] TOP    = '1;

    logic [CODE_W-1:0] off_val;

    always_comb begin
        // adding half scale modulo 2^CODE_W
        off_val = signed_i ? (val_i + OFFSET) : val_i;
        if (plus_one_i) code_o = (off_val == TOP) ? TOP : off_val + 1'b1;
        else            code_o = off_val;
    end

    // R10: saturating plus-one never wraps to zero
    always_comb begin
        p_sat_r10: assert (!(plus_one_i && off_val == TOP) || code_o == TOP);
    end

endmodule

// File: rtl/dac_dgl_timer.sv
module dac_dgl_timer #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    input  logic             en_i,
    input  logic             path_buf_i,
    input  logic [CNT_W-1:0] len_i,
    output logic             pin_open_o,
    output logic             buf_open_o
);
    logic [CNT_W-1:0] cnt_q, cnt_d;
    logic             load;

    always_comb begin
        load = start_i & en_i;
        if (load)              cnt_d = len_i;
        else if (cnt_q != '0)  cnt_d = cnt_q - 1'b1;
        else                   cnt_d = cnt_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign buf_open_o = (cnt_q != '0) &  path_buf_i;
    assign pin_open_o = (cnt_q != '0) & ~path_buf_i;

    // R12: window shrinks by one each cycle without a reload
    p_dgl_step_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_q != '0 && !load) |=> cnt_q == $past(cnt_q) - 1'b1);

    // R12: never both switches open
    p_dgl_excl_r12: assert property (@(posedge clk) disable iff (!rst_n)
        !(pin_open_o && buf_open_o));

endmodule

// File: rtl/dac_update_ctrl.sv
module dac_update_ctrl
    import dac_upd_pkg::*;
#(
    parameter int CODE_W = 12,
    parameter int BUS_W  = 16,
    parameter int DGL_W  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [2:0]        cfg_mode,
    input  logic              cfg_signed,
    input  logic              cfg_plus_one,
    input  logic              cfg_irq_en,
    input  logic              cfg_dgl_en,
    input  logic              cfg_dgl_path,
    input  logic [DGL_W-1:0]  cfg_dgl_cycles,
    input  logic              wr_cur_en,
    input  logic              wr_nxt_en,
    input  logic [BUS_W-1:0]  wr_data,
    input  logic              irq_clr,
    input  logic              upd_clk_in,
    input  logic              strobe_in,
    output logic [CODE_W-1:0] dac_code,
    output logic              trig_out,
    output logic              irq_status,
    output logic              irq_out,
    output logic              sw_pin_open,
    output logic              sw_buf_open
);
    localparam int N_SYNC  = 2;
    localparam int TRIG_W  = $clog2(TRIG_LEN + 1);

    typedef struct packed {
        logic [CODE_W-1:0] cur;
        logic [CODE_W-1:0] nxt;
        logic              armed;
        logic [TRIG_W-1:0] trig_cnt;
        logic              irq;
    } ctl_t;

    ctl_t r_q, r_d;

    // index 0: update clock, index 1: strobe
    logic [N_SYNC-1:0] raw_in, sync_lvl, sync_rise;
    assign raw_in = {strobe_in, upd_clk_in};

    genvar gi;
    generate
        for (gi = 0; gi < N_SYNC; gi++) begin : g_sync
            dac_edge_sync u_sync (
                .clk      (clk),
                .rst_n    (rst_n),
                .async_in (raw_in[gi]),
                .level_o  (sync_lvl[gi]),
                .rise_o   (sync_rise[gi])
            );
        end
    endgenerate

    upd_mode_e mode;
    logic      xfer;
    logic      cur_wr;

    always_comb begin
        mode   = upd_mode_e'(cfg_mode);
        cur_wr = wr_cur_en && (mode == UPD_DIRECT);
        unique case (mode)
            UPD_BUFFERED:  xfer = sync_rise[0];
            UPD_STB_ARM:   xfer = r_q.armed & sync_rise[0];
            UPD_STB_IMM:   xfer = sync_rise[1];
            UPD_STB_LEVEL: xfer = sync_rise[0] & sync_lvl[1];
            default:       xfer = 1'b0;
        endcase

        r_d = r_q;
        if (xfer)        r_d.cur = r_q.nxt;
        else if (cur_wr) r_d.cur = wr_data[CODE_W-1:0];

        if (wr_nxt_en)   r_d.nxt = wr_data[CODE_W-1:0];

        if (mode == UPD_STB_ARM)
            r_d.armed = sync_rise[1] | (r_q.armed & ~sync_rise[0]);
        else
            r_d.armed = 1'b0;

        if (xfer)                  r_d.trig_cnt = TRIG_W'(TRIG_LEN);
        else if (r_q.trig_cnt != 0) r_d.trig_cnt = r_q.trig_cnt - 1'b1;

        r_d.irq = xfer | (r_q.irq & ~irq_clr);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    dac_code_fmt #(.CODE_W(CODE_W)) u_fmt (
        .val_i      (r_q.cur),
        .signed_i   (cfg_signed),
        .plus_one_i (cfg_plus_one),
        .code_o     (dac_code)
    );

    dac_dgl_timer #(.CNT_W(DGL_W)) u_dgl (
        .clk        (clk),
        .rst_n      (rst_n),
        .start_i    (xfer | cur_wr),
        .en_i       (cfg_dgl_en),
        .path_buf_i (cfg_dgl_path),
        .len_i      (cfg_dgl_cycles),
        .pin_open_o (sw_pin_open),
        .buf_open_o (sw_buf_open)
    );

    assign trig_out   = (r_q.trig_cnt != 0);
    assign irq_status = r_q.irq;
    assign irq_out    = r_q.irq & cfg_irq_en;

    // R4: a trigger, once raised, is still high in the next cycle
    p_trig_pair_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(trig_out) |=> trig_out);

    // R1: a new trigger never follows a direct-mode cycle
    p_trig_mode_r1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(trig_out) |-> $past(cfg_mode) != 3'(UPD_DIRECT));

    // R5: trigger start and status set coincide
    p_irq_with_trig_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(trig_out) |-> irq_status);

    // R5: status is sticky until cleared
    p_irq_sticky_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_status && !irq_clr) |=> irq_status);

    // R2: the live value changes only through a transfer or a direct write
    p_cur_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!xfer && !cur_wr) |=> $stable(r_q.cur));

endmodule

// File: tb/dac_update_ctrl_tb.sv
module dac_update_ctrl_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [2:0]  cfg_mode = 3'd0;
    logic        cfg_signed = 1'b0, cfg_plus_one = 1'b0, cfg_irq_en = 1'b1;
    logic        cfg_dgl_en = 1'b0, cfg_dgl_path = 1'b0;
    logic [7:0]  cfg_dgl_cycles = 8'd0;
    logic        wr_cur_en = 1'b0, wr_nxt_en = 1'b0, irq_clr = 1'b0;
    logic [15:0] wr_data = 16'd0;
    logic        upd_clk_in = 1'b0, strobe_in = 1'b0;
    logic [11:0] dac_code;
    logic        trig_out, irq_status, irq_out, sw_pin_open, sw_buf_open;

    always #2 clk = ~clk;

    dac_update_ctrl u_dut (
        .clk(clk), .rst_n(rst_n), .cfg_mode(cfg_mode), .cfg_signed(cfg_signed),
        .cfg_plus_one(cfg_plus_one), .cfg_irq_en(cfg_irq_en), .cfg_dgl_en(cfg_dgl_en),
        .cfg_dgl_path(cfg_dgl_path), .cfg_dgl_cycles(cfg_dgl_cycles),
        .wr_cur_en(wr_cur_en), .wr_nxt_en(wr_nxt_en), .wr_data(wr_data),
        .irq_clr(irq_clr), .upd_clk_in(upd_clk_in), .strobe_in(strobe_in),
        .dac_code(dac_code), .trig_out(trig_out), .irq_status(irq_status),
        .irq_out(irq_out), .sw_pin_open(sw_pin_open), .sw_buf_open(sw_buf_open)
    );

    int n_chk = 0, n_bad = 0;
    int trig_hi = 0, pin_hi = 0, buf_hi = 0;
    bit cmp_on = 0;
    bit done = 0;

    task automatic chk(string tag, int act, int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
        end
    endtask

    // ---------------- behavioural reference model ----------------
    int m_cur = 0, m_nxt = 0, m_arm = 0, m_trig = 0, m_irq = 0, m_dgl = 0;
    int uc1 = 0, uc2 = 0, uc3 = 0, sb1 = 0, sb2 = 0, sb3 = 0;

    function automatic int fmt(int v);
        int r;
        r = cfg_signed ? ((v + 2048) % 4096) : v;
        if (cfg_plus_one) r = (r == 4095) ? 4095 : r + 1;
        return r;
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            m_cur = 0; m_nxt = 0; m_arm = 0; m_trig = 0; m_irq = 0; m_dgl = 0;
            uc1 = 0; uc2 = 0; uc3 = 0; sb1 = 0; sb2 = 0; sb3 = 0;
        end else begin
            int crise, srise, slvl, xf, wrc;
            crise = uc2 && !uc3;
            srise = sb2 && !sb3;
            slvl  = sb2;
            case (cfg_mode)
                3'd1: xf = crise;
                3'd2: xf = m_arm && crise;
                3'd3: xf = srise;
                3'd4: xf = crise && slvl;
                default: xf = 0;
            endcase
            wrc = wr_cur_en && (cfg_mode == 3'd0);
            if (xf) m_cur = m_nxt;
            else if (wrc) m_cur = int'(wr_data[11:0]);
            if (wr_nxt_en) m_nxt = int'(wr_data[11:0]);
            if (cfg_mode == 3'd2) m_arm = (srise || (m_arm && !crise)) ? 1 : 0;
            else m_arm = 0;
            m_trig = xf ? 2 : (m_trig > 0 ? m_trig - 1 : 0);
            m_irq = (xf || (m_irq && !irq_clr)) ? 1 : 0;
            if ((xf || wrc) && cfg_dgl_en) m_dgl = int'(cfg_dgl_cycles);
            else if (m_dgl > 0) m_dgl = m_dgl - 1;
            uc3 = uc2; uc2 = uc1; uc1 = int'(upd_clk_in);
            sb3 = sb2; sb2 = sb1; sb1 = int'(strobe_in);
        end
    end

    // per-cycle comparison away from the clock edge
    always begin
        @(negedge clk);
        #1;
        if (rst_n && cmp_on) begin
            chk("R9 model code", int'(dac_code), fmt(m_cur));
            chk("R4 model trig", int'(trig_out), m_trig > 0 ? 1 : 0);
            chk("R5 model status", int'(irq_status), m_irq);
            chk("R11 model irq_out", int'(irq_out), m_irq & int'(cfg_irq_en));
            chk("R12 model pin", int'(sw_pin_open), (m_dgl > 0 && !cfg_dgl_path) ? 1 : 0);
            chk("R12 model buf", int'(sw_buf_open), (m_dgl > 0 && cfg_dgl_path) ? 1 : 0);
        end
        if (trig_out) trig_hi++;
        if (sw_pin_open) pin_hi++;
        if (sw_buf_open) buf_hi++;
    end

    // ---------------- stimulus helpers ----------------
    task automatic cyc(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr_cur(int v);
        @(negedge clk); wr_cur_en = 1; wr_data = 16'(v);
        @(negedge clk); wr_cur_en = 0;
    endtask

    task automatic wr_nxt(int v);
        @(negedge clk); wr_nxt_en = 1; wr_data = 16'(v);
        @(negedge clk); wr_nxt_en = 0;
    endtask

    task automatic pulse_clk();
        @(negedge clk); upd_clk_in = 1;
        cyc(2); upd_clk_in = 0;
        cyc(2);
    endtask

    task automatic pulse_stb();
        @(negedge clk); strobe_in = 1;
        cyc(2); strobe_in = 0;
        cyc(2);
    endtask

    task automatic look();
        @(negedge clk); #2;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog act=hung exp=finished");
            $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        int seed;
        cyc(4);
        #1;
        chk("R13 reset code", int'(dac_code), 0);
        chk("R13 reset trig", int'(trig_out), 0);
        chk("R13 reset irq", int'(irq_status) + int'(irq_out), 0);
        chk("R13 reset switches", int'(sw_pin_open) + int'(sw_buf_open), 0);
        @(negedge clk); rst_n = 1; cmp_on = 1;
        cyc(3);

        // direct mode
        trig_hi = 0;
        wr_cur(12'h123);
        look();
        chk("R1 direct code", int'(dac_code), 12'h123);
        chk("R1 direct no irq", int'(irq_status), 0);
        chk("R1 direct no trig", trig_hi, 0);
        wr_nxt(12'h456);
        pulse_clk(); pulse_stb();
        look();
        chk("R2 next ignored in direct", int'(dac_code), 12'h123);

        // buffered mode
        @(negedge clk); cfg_mode = 3'd1;
        wr_cur(12'h777);
        look();
        chk("R2 live write ignored", int'(dac_code), 12'h123);
        trig_hi = 0;
        pulse_clk(); cyc(2);
        chk("R3 buffered transfer", int'(dac_code), 12'h456);
        chk("R5 status set", int'(irq_status), 1);
        chk("R11 irq_out enabled", int'(irq_out), 1);
        chk("R4 trigger width", trig_hi, 2);
        wr_nxt(16'hF9AB);
        @(negedge clk); upd_clk_in = 1;
        cyc(2); #2;
        chk("R3 not yet at second edge", int'(dac_code), 12'h456);
        @(negedge clk); #2;
        chk("R3 lands at third edge", int'(dac_code), 12'h9AB);
        chk("R9 upper bits dropped", int'(dac_code), 12'h9AB);
        @(negedge clk); upd_clk_in = 0;
        cyc(2);
        @(negedge clk); irq_clr = 1;
        @(negedge clk); irq_clr = 0; #2;
        chk("R5 cleared", int'(irq_status), 0);
        @(negedge clk); cfg_irq_en = 0;
        pulse_clk(); cyc(2);
        chk("R11 status set while masked", int'(irq_status), 1);
        chk("R11 line masked", int'(irq_out), 0);
        @(negedge clk); irq_clr = 1; cfg_irq_en = 1;
        @(negedge clk); irq_clr = 0;

        // strobe-armed mode
        @(negedge clk); cfg_mode = 3'd2;
        wr_nxt(12'h222);
        pulse_clk(); cyc(2);
        chk("R6 no transfer unarmed", int'(dac_code), 12'h9AB);
        pulse_stb(); cyc(2);
        chk("R6 strobe alone no transfer", int'(dac_code), 12'h9AB);
        pulse_clk(); cyc(2);
        chk("R6 armed transfer", int'(dac_code), 12'h222);
        wr_nxt(12'h333);
        pulse_clk(); cyc(2);
        chk("R6 one transfer per arm", int'(dac_code), 12'h222);

        // strobe-immediate mode
        @(negedge clk); cfg_mode = 3'd3;
        wr_nxt(12'h444);
        pulse_clk(); cyc(2);
        chk("R7 clock ignored", int'(dac_code), 12'h222);
        pulse_stb(); cyc(2);
        chk("R7 strobe transfers", int'(dac_code), 12'h444);

        // strobe-level mode
        @(negedge clk); cfg_mode = 3'd4;
        wr_nxt(12'h555);
        pulse_clk(); cyc(2);
        chk("R8 gated low", int'(dac_code), 12'h444);
        @(negedge clk); strobe_in = 1;
        cyc(3);
        pulse_clk(); cyc(2);
        chk("R8 gated high", int'(dac_code), 12'h555);
        @(negedge clk); strobe_in = 0;
        cyc(3);

        // reserved mode
        @(negedge clk); cfg_mode = 3'd6;
        wr_nxt(12'h666); wr_cur(12'h667);
        pulse_clk(); pulse_stb(); cyc(2);
        chk("R2 reserved mode idle", int'(dac_code), 12'h555);

        // formatting
        @(negedge clk); cfg_mode = 3'd0; cfg_signed = 1;
        wr_cur(12'h000); look();
        chk("R9 signed zero", int'(dac_code), 12'h800);
        wr_cur(12'h7FF); look();
        chk("R9 signed max", int'(dac_code), 12'hFFF);
        wr_cur(12'h800); look();
        chk("R9 signed min", int'(dac_code), 12'h000);
        @(negedge clk); cfg_signed = 0; cfg_plus_one = 1;
        wr_cur(12'hFFF); look();
        chk("R10 saturate", int'(dac_code), 12'hFFF);
        wr_cur(12'h0FE); look();
        chk("R10 plus one", int'(dac_code), 12'h0FF);
        @(negedge clk); cfg_plus_one = 0;

        // deglitch
        @(negedge clk); cfg_dgl_en = 1; cfg_dgl_path = 1; cfg_dgl_cycles = 8'd5;
        cyc(1); pin_hi = 0; buf_hi = 0;
        wr_cur(12'h321); cyc(10);
        chk("R12 buffered switch window", buf_hi, 5);
        chk("R12 pin switch closed", pin_hi, 0);
        @(negedge clk); cfg_dgl_path = 0; cfg_dgl_cycles = 8'd3; cfg_mode = 3'd1;
        cyc(1); pin_hi = 0; buf_hi = 0;
        pulse_clk(); cyc(8);
        chk("R12 pin switch window", pin_hi, 3);
        chk("R12 buffered switch closed", buf_hi, 0);

        // pseudo-random phase, checked by the model each cycle
        seed = 32'h1357;
        for (int md = 0; md < 5; md++) begin
            @(negedge clk); cfg_mode = 3'(md);
            cfg_signed = md[0]; cfg_plus_one = md[1];
            cfg_dgl_path = md[0]; cfg_dgl_cycles = 8'(md + 2);
            for (int i = 0; i < 400; i++) begin
                @(negedge clk);
                seed = seed * 1103515245 + 12345;
                wr_nxt_en  = seed[20];
                wr_cur_en  = seed[21] & seed[22];
                wr_data    = seed[31:16];
                irq_clr    = seed[23] & seed[24] & seed[25];
                if (seed[26] & seed[27]) upd_clk_in = ~upd_clk_in;
                if (seed[28] & seed[29] & seed[30]) strobe_in = ~strobe_in;
            end
        end
        @(negedge clk); wr_nxt_en = 0; wr_cur_en = 0; irq_clr = 0;
        cyc(10);

        done = 1;
        $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

endmodule